// File: doc/BRIEF.md
# Two-Wire Configuration Register Target

This block is the serial front end of a jumper-replacement configuration device. It sits on a two-wire (I2C/SMBus) bus, oversamples SCL and SDA with the system clock, and drives SDA through an open-drain enable. Each transfer begins with an address byte. The block answers only to its own address. On a write, the next byte is a command. A command either points at one of three registers or forces the source of the device's downstream outputs.

Two 6-bit configuration bytes are modelled as non-volatile storage built from flip-flops. A write transaction stages at most two data bytes. They are copied into storage only when STOP arrives and only if write-protect is low. After a copy, the device refuses its own address for a busy interval of 3.6 ms, counted in system clock cycles. Reads return the configuration bytes or the live value of five external pin inputs. The stored bytes and the current source-override mode are exported for the output multiplexer that sits next to this block.

Top module: `cfg_i2c_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal binary 10011 followed by strap_i[1] and strap_i[0]. Bit 0 of that byte is 1 for a read and 0 for a write. Any other address is left unacknowledged, with SDA released.
- R2: Command codes 0x00, 0x01 and 0xFF, and every code of the form 11111xxx, are acknowledged. Every other code is reserved. A reserved code is not acknowledged and changes neither the pointer nor the mode.
- R3: src_sel_o resets to 0, which means the output source follows the select pins. The codes set it as follows: 0xF8 sets 1 (configuration byte 0), 0xFC sets 2 (configuration byte 1), 11111x10 sets 3 (external pins), and any other 11111xx1 code except 0xFF sets 0. Pointer codes leave it unchanged.
- R4: After command 0x00 (pointer to byte 0) or 0x01 (pointer to byte 1), the first data byte is written to the pointed byte and a second data byte to the other byte. A third data byte is not acknowledged, and then neither byte is written.
- R5: Configuration outputs change only when a STOP condition ends a write that holds accepted data. They never change while the transaction is still in progress.
- R6: While wp_i is high, the address and command are acknowledged, but data bytes are not acknowledged and nothing is stored. If wp_i is high when STOP arrives, staged data is dropped.
- R7: A read of a configuration byte returns 00 followed by the six stored bits: bit 5 is the non-multiplexed bit and bits 4:0 are pin data E..A. A read after command 0xFF returns 000 followed by pins_i[4:0]. That register is read-only, so a data byte written to it is not acknowledged.
- R8: Each byte read from or written to a configuration register moves the pointer to the other configuration register. The pointer persists across repeated START and across separate transactions.
- R9: A data byte that follows an override command is not acknowledged.
- R10: For BUSY cycles after a committed write, the device leaves its own address unacknowledged. After that it acknowledges again. A transaction that commits nothing starts no busy interval.
- R11: After reset, both configuration bytes are zero, src_sel_o is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | When 1, pull SDA low |
| strap_i | input | 2 | Address strap inputs, low two address bits |
| wp_i | input | 1 | Write-protect, active high |
| pins_i | input | PIN_BITS | External pin values readable over the bus |
| cfg0_o | output | NV_BITS | Stored configuration byte 0 |
| cfg1_o | output | NV_BITS | Stored configuration byte 1 |
| src_sel_o | output | 2 | Output-source override mode |

## Verification
Write traffic is varied along several axes: one data byte, two data bytes and three data bytes; write-protect high during the data phase and write-protect raised only before STOP; pointer, override and reserved commands. Together these separate the commit path from the acceptance path. Read traffic includes back-to-back bytes within one transfer, single-byte reads spread across separate transfers, and a pointer set just before a repeated START. This shows whether the pointer advances per byte and whether it persists. Pin reads are repeated with two different pin patterns, so a stale copy cannot be mistaken for the live value. An address is also sent just after a commit and again after the busy interval, which brackets the busy window.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
   typedef enum logic [1:0] {PTR_CFG0 = 2'd0, PTR_CFG1 = 2'd1, PTR_PINS = 2'd2} ptr_e;
   typedef enum logic [1:0] {SRC_SELPINS = 2'd0, SRC_CFG0 = 2'd1, SRC_CFG1 = 2'd2, SRC_EXT = 2'd3} src_e;
   typedef enum logic [1:0] {CK_PTR, CK_OVR, CK_RSVD} cmd_kind_e;
   typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TACK} lnk_st_e;
   typedef enum logic [1:0] {RL_ADDR, RL_CMD, RL_DATA} role_e;
   localparam logic [4:0] ADDR_HI = 5'b10011;
endpackage

// File: rtl/cfg_bus_sampler.sv
module cfg_bus_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
         scl_p  <= scl_sh[SYNC_STAGES-1];
         sda_p  <= sda_sh[SYNC_STAGES-1];
      end
   end

   assign scl_o      = scl_sh[SYNC_STAGES-1];
   assign sda_o      = sda_sh[SYNC_STAGES-1];
   assign scl_rise_o = scl_o & ~scl_p;
   assign scl_fall_o = ~scl_o & scl_p;
   assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
   assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
   import cfg_i2c_pkg::*;
(
   input  logic [7:0] code_i,
   output cmd_kind_e  kind_o,
   output ptr_e       ptr_o,
   output src_e       src_o
);
   always_comb begin
      kind_o = CK_RSVD;
      ptr_o  = PTR_CFG0;
      src_o  = SRC_SELPINS;
      casez (code_i)
         8'h00:        kind_o = CK_PTR;
         8'h01:        begin kind_o = CK_PTR; ptr_o = PTR_CFG1; end
         8'hFF:        begin kind_o = CK_PTR; ptr_o = PTR_PINS; end
         8'hF8:        begin kind_o = CK_OVR; src_o = SRC_CFG0; end
         8'hFC:        begin kind_o = CK_OVR; src_o = SRC_CFG1; end
         8'b11111?10:  begin kind_o = CK_OVR; src_o = SRC_EXT; end
         8'b11111??1:  begin kind_o = CK_OVR; src_o = SRC_SELPINS; end
         default:      kind_o = CK_RSVD;
      endcase
   end
endmodule

// File: rtl/cfg_nv_store.sv
module cfg_nv_store #(
   parameter int NV_BITS        = 6,
   parameter int CLK_HZ         = 50_000_000,
   parameter int BUSY_TENTHS_MS = 36
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    commit_i,
   input  logic [1:0]              stg_v_i,
   input  logic [1:0][NV_BITS-1:0] stg_d_i,
   output logic [1:0][NV_BITS-1:0] cfg_o,
   output logic                    busy_o
);
   localparam int BUSY_CYC = CLK_HZ / 10000 * BUSY_TENTHS_MS;
   localparam int CW       = $clog2(BUSY_CYC + 1);

   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("busy interval must be at least one cycle");
   end

   for (genvar g = 0; g < 2; g++) begin : g_reg
      logic [NV_BITS-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    val_q <= '0;
         else if (commit_i && stg_v_i[g]) val_q <= stg_d_i[g];
      end
      assign cfg_o[g] = val_q;
   end

   logic [CW-1:0] cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (commit_i)     cnt_q <= CW'(BUSY_CYC);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end
   assign busy_o = (cnt_q != '0);

   p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> $stable(cfg_o));
   p_commit_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |-> !busy_o);
   p_busy_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |=> busy_o);
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
   import cfg_i2c_pkg::*;
#(
   parameter int NV_BITS        = 6,
   parameter int PIN_BITS       = 5,
   parameter int CLK_HZ         = 50_000_000,
   parameter int BUSY_TENTHS_MS = 36,
   parameter int SYNC_STAGES    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_i,
   input  logic                sda_i,
   output logic                sda_oe_o,
   input  logic [1:0]          strap_i,
   input  logic                wp_i,
   input  logic [PIN_BITS-1:0] pins_i,
   output logic [NV_BITS-1:0]  cfg0_o,
   output logic [NV_BITS-1:0]  cfg1_o,
   output logic [1:0]          src_sel_o
);
   if (NV_BITS < 1 || NV_BITS > 8) begin : g_bad_nv
      $error("NV_BITS must be 1..8");
   end
   if (PIN_BITS < 1 || PIN_BITS > 8) begin : g_bad_pins
      $error("PIN_BITS must be 1..8");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   cfg_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start_ev), .stop_o(stop_ev));

   lnk_st_e st_q;
   role_e   role_q;
   ptr_e    ptr_q;
   src_e    src_q;
   logic [3:0] bit_q;
   logic [7:0] sh_q;
   logic       oe_q, rd_q, ovr_cmd_q, void_q, tack_q;
   logic [1:0] wcnt_q, stg_v_q;
   logic [1:0][NV_BITS-1:0] stg_d_q;

   cmd_kind_e dec_kind;
   ptr_e      dec_ptr;
   src_e      dec_src;
   cfg_cmd_decode u_dec (.code_i(sh_q), .kind_o(dec_kind), .ptr_o(dec_ptr), .src_o(dec_src));

   logic [1:0][NV_BITS-1:0] cfg_w;
   logic busy, commit;
   cfg_nv_store #(.NV_BITS(NV_BITS), .CLK_HZ(CLK_HZ), .BUSY_TENTHS_MS(BUSY_TENTHS_MS)) u_nv (
      .clk(clk), .rst_n(rst_n), .commit_i(commit), .stg_v_i(stg_v_q), .stg_d_i(stg_d_q),
      .cfg_o(cfg_w), .busy_o(busy));

   logic       addr_hit, data_ok;
   logic [7:0] tx_byte;
   ptr_e       ptr_nxt;

   assign addr_hit = (sh_q[7:1] == {ADDR_HI, strap_i});
   assign data_ok  = (ptr_q != PTR_PINS) && !ovr_cmd_q && !wp_i && (wcnt_q < 2'd2);
   assign commit   = stop_ev && (stg_v_q != 2'b00) && !void_q && !wp_i;
   assign ptr_nxt  = (ptr_q == PTR_CFG0) ? PTR_CFG1 : (ptr_q == PTR_CFG1) ? PTR_CFG0 : ptr_q;

   always_comb begin
      tx_byte = '0;
      if (ptr_q == PTR_PINS) tx_byte[PIN_BITS-1:0] = pins_i;
      else                   tx_byte[NV_BITS-1:0]  = cfg_w[ptr_q[0]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE; role_q <= RL_ADDR; ptr_q <= PTR_CFG0; src_q <= SRC_SELPINS;
         bit_q <= '0; sh_q <= '0; oe_q <= 1'b0; rd_q <= 1'b0; ovr_cmd_q <= 1'b0;
         void_q <= 1'b0; tack_q <= 1'b0; wcnt_q <= '0; stg_v_q <= '0; stg_d_q <= '0;
      end else if (stop_ev) begin
         st_q <= ST_IDLE; oe_q <= 1'b0; stg_v_q <= '0; void_q <= 1'b0; wcnt_q <= '0;
      end else if (start_ev) begin
         st_q <= ST_RX; role_q <= RL_ADDR; bit_q <= '0; oe_q <= 1'b0;
      end else begin
         case (st_q)
            ST_RX: begin
               if (scl_rise) begin
                  sh_q  <= {sh_q[6:0], sda_s};
                  bit_q <= bit_q + 4'd1;
               end else if (scl_fall && bit_q == 4'd8) begin
                  st_q  <= ST_ACK;
                  bit_q <= '0;
                  case (role_q)
                     RL_ADDR: begin
                        if (addr_hit && !busy) begin oe_q <= 1'b1; rd_q <= sh_q[0]; end
                        else st_q <= ST_IDLE;
                     end
                     RL_CMD: begin
                        if (dec_kind != CK_RSVD) begin
                           oe_q      <= 1'b1;
                           ovr_cmd_q <= (dec_kind == CK_OVR);
                           if (dec_kind == CK_PTR) begin
                              ptr_q <= dec_ptr; stg_v_q <= '0; wcnt_q <= '0; void_q <= 1'b0;
                           end else begin
                              src_q <= dec_src;
                           end
                        end else st_q <= ST_IDLE;
                     end
                     default: begin
                        if (data_ok) begin
                           oe_q <= 1'b1;
                           stg_d_q[ptr_q[0]] <= sh_q[NV_BITS-1:0];
                           stg_v_q[ptr_q[0]] <= 1'b1;
                           ptr_q  <= ptr_nxt;
                           wcnt_q <= wcnt_q + 2'd1;
                        end else begin
                           st_q <= ST_IDLE;
                           if (wcnt_q == 2'd2) void_q <= 1'b1;
                        end
                     end
                  endcase
               end
            end
            ST_ACK: if (scl_fall) begin
               bit_q <= '0;
               if (role_q == RL_ADDR && rd_q) begin
                  st_q <= ST_TX; sh_q <= tx_byte; oe_q <= ~tx_byte[7]; ptr_q <= ptr_nxt;
               end else begin
                  st_q <= ST_RX; oe_q <= 1'b0;
                  role_q <= (role_q == RL_ADDR) ? RL_CMD : RL_DATA;
               end
            end
            ST_TX: if (scl_fall) begin
               if (bit_q == 4'd7) begin
                  oe_q <= 1'b0; st_q <= ST_TACK;
               end else begin
                  sh_q <= {sh_q[6:0], 1'b0}; oe_q <= ~sh_q[6]; bit_q <= bit_q + 4'd1;
               end
            end
            ST_TACK: begin
               if (scl_rise) tack_q <= ~sda_s;
               else if (scl_fall) begin
                  bit_q <= '0;
                  if (tack_q) begin
                     st_q <= ST_TX; sh_q <= tx_byte; oe_q <= ~tx_byte[7]; ptr_q <= ptr_nxt;
                  end else st_q <= ST_IDLE;
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe_o  = oe_q;
   assign cfg0_o    = cfg_w[0];
   assign cfg1_o    = cfg_w[1];
   assign src_sel_o = src_q;

   p_drive_low_scl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> !scl_s);
   p_src_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_q == ST_RX && scl_fall) |=> $stable(src_q));
   p_stage_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      {30'd0, wcnt_q} == $countones(stg_v_q));
endmodule

// File: tb/sim_cfg_i2c_target.sv
module sim_cfg_i2c_target;
   localparam int CLK_HZ = 100_000;
   localparam int BUSY   = CLK_HZ / 10000 * 36;
   localparam int Q      = 4;
   localparam logic [7:0] AW = 8'h9C;
   localparam logic [7:0] AR = 8'h9D;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
   logic [1:0] strap = 2'b10;
   logic [4:0] pins = 5'h13;
   logic sda_oe;
   logic [5:0] cfg0, cfg1;
   logic [1:0] src;
   wire sda_bus = m_sda & ~sda_oe;

   cfg_i2c_target #(.CLK_HZ(CLK_HZ)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
      .strap_i(strap), .wp_i(wp), .pins_i(pins), .cfg0_o(cfg0), .cfg1_o(cfg1), .src_sel_o(src));

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic qtr(); repeat (Q) @(negedge clk); endtask
   task automatic i2c_start();
      m_sda = 1'b1; qtr(); m_scl = 1'b1; qtr(); m_sda = 1'b0; qtr(); m_scl = 1'b0; qtr();
   endtask
   task automatic i2c_stop();
      m_sda = 1'b0; qtr(); m_scl = 1'b1; qtr(); m_sda = 1'b1; qtr(); qtr();
   endtask
   task automatic send_byte(input logic [7:0] b, output int ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; qtr(); m_scl = 1'b1; qtr(); m_scl = 1'b0; qtr();
      end
      m_sda = 1'b1; qtr(); m_scl = 1'b1; qtr();
      ack = sda_bus ? 0 : 1;
      m_scl = 1'b0; qtr();
   endtask
   task automatic recv_byte(input bit give_ack, output int b);
      b = 0;
      m_sda = 1'b1;
      for (int i = 0; i < 8; i++) begin
         qtr(); m_scl = 1'b1; qtr();
         b = (b << 1) | int'(sda_bus);
         m_scl = 1'b0;
      end
      m_sda = give_ack ? 1'b0 : 1'b1; qtr(); m_scl = 1'b1; qtr(); m_scl = 1'b0; qtr();
      m_sda = 1'b1;
   endtask
   task automatic settle(); repeat (8) @(negedge clk); endtask
   task automatic wait_busy(); repeat (BUSY + 50) @(negedge clk); endtask

   task automatic t_reset();
      chk("R11 cfg0 reset", int'(cfg0), 0);
      chk("R11 cfg1 reset", int'(cfg1), 0);
      chk("R11 mode reset", int'(src), 0);
      chk("R11 sda released", int'(sda_oe), 0);
   endtask

   task automatic t_addr();
      int a;
      i2c_start(); send_byte(8'h9E, a); chk("R1 strap mismatch nack", a, 0); i2c_stop();
      i2c_start(); send_byte(8'h1C, a); chk("R1 fixed bits mismatch nack", a, 0); i2c_stop();
      i2c_start(); send_byte(AW, a); chk("R1 own address ack", a, 1);
      send_byte(8'h00, a); chk("R2 pointer code ack", a, 1); i2c_stop();
   endtask

   task automatic t_one_byte();
      int a;
      i2c_start(); send_byte(AW, a); send_byte(8'h01, a);
      send_byte(8'hFF, a); chk("R4 single data ack", a, 1);
      chk("R5 no change before stop", int'(cfg1), 0);
      i2c_stop(); settle();
      chk("R4 byte1 written, upper bits ignored", int'(cfg1), 'h3F);
      chk("R4 byte0 untouched", int'(cfg0), 0);
      i2c_start(); send_byte(AW, a); chk("R10 nack during busy", a, 0); i2c_stop();
      wait_busy();
      i2c_start(); send_byte(AW, a); chk("R10 ack after busy", a, 1); i2c_stop();
   endtask

   task automatic t_two_bytes();
      int a;
      i2c_start(); send_byte(AW, a); send_byte(8'h00, a);
      send_byte(8'hEA, a); chk("R4 first data ack", a, 1);
      send_byte(8'h15, a); chk("R4 second data ack", a, 1);
      chk("R5 cfg0 held before stop", int'(cfg0), 0);
      i2c_stop(); settle();
      chk("R4 first to pointed byte", int'(cfg0), 'h2A);
      chk("R4 second to other byte", int'(cfg1), 'h15);
      wait_busy();
   endtask

   task automatic t_read();
      int a, d;
      i2c_start(); send_byte(AR, a); chk("R1 read address ack", a, 1);
      recv_byte(1'b1, d); chk("R7 read byte0 format", d, 'h2A);
      recv_byte(1'b0, d); chk("R8 auto advance in read", d, 'h15);
      i2c_stop();
      i2c_start(); send_byte(AR, a); recv_byte(1'b0, d); i2c_stop();
      chk("R8 pointer persists across transfers", d, 'h2A);
      i2c_start(); send_byte(AW, a); send_byte(8'h01, a);
      i2c_start(); send_byte(AR, a); recv_byte(1'b0, d); i2c_stop();
      chk("R8 pointer kept over repeated start", d, 'h15);
      i2c_start(); send_byte(AR, a); recv_byte(1'b0, d); i2c_stop();
      chk("R8 advance after single read", d, 'h2A);
   endtask

   task automatic t_pins();
      int a, d;
      i2c_start(); send_byte(AW, a); send_byte(8'hFF, a); chk("R2 pin pointer ack", a, 1);
      send_byte(8'h00, a); chk("R7 pin register write nack", a, 0);
      i2c_start(); send_byte(AR, a); recv_byte(1'b0, d); chk("R7 pin read", d, 'h13);
      pins = 5'h0C;
      i2c_start(); send_byte(AR, a); recv_byte(1'b0, d); chk("R7 pin read live", d, 'h0C);
      i2c_stop();
   endtask

   task automatic t_third();
      int a;
      i2c_start(); send_byte(AW, a); send_byte(8'h00, a);
      send_byte(8'h01, a); send_byte(8'h02, a);
      send_byte(8'h03, a); chk("R4 third byte nack", a, 0);
      i2c_stop(); settle();
      chk("R4 voided cfg0", int'(cfg0), 'h2A);
      chk("R4 voided cfg1", int'(cfg1), 'h15);
      i2c_start(); send_byte(AW, a); chk("R10 no busy without commit", a, 1); i2c_stop();
   endtask

   task automatic t_wp();
      int a;
      wp = 1'b1;
      i2c_start(); send_byte(AW, a); chk("R6 address ack under wp", a, 1);
      send_byte(8'h01, a); chk("R6 command ack under wp", a, 1);
      send_byte(8'h05, a); chk("R6 data nack under wp", a, 0);
      i2c_stop(); settle();
      chk("R6 nothing stored", int'(cfg1), 'h15);
      wp = 1'b0;
      i2c_start(); send_byte(AW, a); send_byte(8'h00, a); send_byte(8'h07, a);
      wp = 1'b1; i2c_stop(); settle(); wp = 1'b0;
      chk("R6 wp at stop drops data", int'(cfg0), 'h2A);
   endtask

   task automatic t_reserved();
      int a;
      logic [7:0] codes [3] = '{8'h02, 8'h80, 8'hF0};
      foreach (codes[k]) begin
         i2c_start(); send_byte(AW, a); send_byte(codes[k], a);
         chk("R2 reserved code nack", a, 0); i2c_stop();
      end
      chk("R2 reserved leaves mode", int'(src), 0);
   endtask

   task automatic t_override();
      int a;
      logic [7:0] codes [6] = '{8'hF8, 8'hFC, 8'hFA, 8'hF9, 8'hFE, 8'hFB};
      int modes [6] = '{1, 2, 3, 0, 3, 0};
      foreach (codes[k]) begin
         i2c_start(); send_byte(AW, a); send_byte(codes[k], a);
         chk("R3 override code ack", a, 1);
         chk("R3 override mode", int'(src), modes[k]);
         if (k == 1) begin
            send_byte(8'h2A, a); chk("R9 data after override nack", a, 0);
         end
         i2c_stop();
      end
      settle();
      chk("R9 no store after override", int'(cfg1), 'h15);
      i2c_start(); send_byte(AW, a); send_byte(8'hFA, a); i2c_stop();
      i2c_start(); send_byte(AW, a); send_byte(8'hFF, a); i2c_stop();
      chk("R3 pointer code keeps mode", int'(src), 3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hang expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_addr();
      t_one_byte();
      t_two_bytes();
      t_read();
      t_pins();
      t_third();
      t_wp();
      t_reserved();
      t_override();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule